// File: doc/BRIEF.md
# Accumulator Bit Field Extract and Insert Unit

This unit pulls a bit field out of a wide accumulator value, or writes a field into one. A field is described by one packed descriptor word. Its upper byte holds the field width in bits and its lower byte holds the bit position of the field's least significant bit. An extract right-justifies the selected bits of the source accumulator in the result. The bits above the field are then filled either with copies of the field's top bit (signed mode) or with zeros (unsigned mode). An insert takes the low-order bits of the source accumulator and writes them into the field position of the destination accumulator. It leaves every other destination bit as it was.

The surrounding datapath supplies the operation code, both accumulator values and the descriptor, along with a one-cycle start pulse. A flag tells the unit whether the descriptor came from an instruction immediate or from an auxiliary register. An extract whose descriptor comes from a register finishes in one cycle. An extract with an immediate descriptor, and every insert, takes two cycles, and the unit reports busy during the first of them. The result is registered. A one-cycle valid pulse marks the cycle in which it should be written back.

Top module: `bitfield_unit`

## Requirements
- R1: The descriptor's upper byte (bits 15:8 by default) is the field width in bits, and its lower byte (bits 7:0) is the offset of the field's lowest bit from bit 0.
- R2: Operation code 0 (signed extract) returns source bits [offset+width-1:offset] in result bits [width-1:0], with every higher bit equal to the field's top bit. The destination input has no effect.
- R3: Operation code 1 (unsigned extract) returns the field right-justified, with every higher result bit zero.
- R4: Operation code 2 (insert) returns the destination value with bits [offset+width-1:offset] replaced by source bits [width-1:0], and all other bits unchanged.
- R5: A width of zero gives a result of zero for either extract, and returns the destination unchanged for an insert.
- R6: Field bits that would lie above the top accumulator bit are dropped, and the remaining in-range bits are still processed. A field whose offset is at or beyond the accumulator width therefore behaves like a width of zero.
- R7: An extract accepted with desc_imm=0 raises res_valid in the cycle after start, and busy stays low.
- R8: An extract accepted with desc_imm=1, and any insert, raises busy for one cycle after start and then raises res_valid in the following cycle, with busy low again.
- R9: A start while busy is high, or a start with the reserved operation code 3, is ignored: it produces no extra valid pulse and does not change busy or the pending operation.
- R10: After reset, result, res_valid and busy are all zero. res_valid is a single-cycle pulse caused only by an accepted operation, and result holds its value while res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 0 signed extract, 1 unsigned extract, 2 insert, 3 reserved |
| desc_imm | input | 1 | 1 when the descriptor is an immediate, 0 when it is from a register |
| desc | input | 2*BYTE_W (16) | Field descriptor: width in upper byte, offset in lower byte |
| src_acc | input | ACC_W (36) | Source accumulator value |
| dst_acc | input | ACC_W (36) | Destination accumulator value, used by insert |
| busy | output | 1 | High while a two-cycle operation is in its first cycle |
| result | output | ACC_W (36) | Registered result |
| res_valid | output | 1 | One-cycle pulse when result should be written |

## Verification
The bench builds the unit with its defaults of a 36-bit accumulator and 8-bit descriptor bytes. Widths and offsets can then reach 255, well past the top bit, so the clipping of fields at and beyond bit 35 and the zero-width cases are exercised along with ordinary in-range fields. Both latency classes are run back to back. Starts are also issued during busy and with the reserved code, so the one-cycle and two-cycle timings and the ignore rules are compared cycle by cycle against a bit-loop reference.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int ACC_W_DEFAULT  = 36;
    localparam int BYTE_W_DEFAULT = 8;

    typedef enum logic [1:0] {
        OP_EXT_SIGNED = 2'd0,
        OP_EXT_ZERO   = 2'd1,
        OP_INSERT     = 2'd2,
        OP_RESERVED   = 2'd3
    } bf_op_e;

    function automatic logic op_accepted(input bf_op_e code);
        return code != OP_RESERVED;
    endfunction

    // Immediate descriptors and all inserts need a second cycle.
    function automatic logic op_needs_two(input bf_op_e code, input logic from_imm);
        return (code == OP_INSERT) || from_imm;
    endfunction

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEFAULT,
    parameter int BYTE_W = BYTE_W_DEFAULT,
    localparam int DESC_W = 2 * BYTE_W,
    localparam int CNT_W  = $clog2(ACC_W + 1)
) (
    input  logic [DESC_W-1:0] desc,
    output logic [CNT_W-1:0]  eff_width,
    output logic [BYTE_W-1:0] offset
);

    int req_w;
    int req_o;
    int room;
    int eff;

    always_comb begin
        req_w  = int'(desc[DESC_W-1:BYTE_W]);
        req_o  = int'(desc[BYTE_W-1:0]);
        offset = desc[BYTE_W-1:0];
        if (req_o >= ACC_W) begin
            room = 0;
        end else begin
            room = ACC_W - req_o;
        end
        eff       = (req_w < room) ? req_w : room;
        eff_width = CNT_W'(eff);
    end

endmodule

// File: rtl/bfx_extract.sv
module bfx_extract
    import bfx_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEFAULT,
    parameter int BYTE_W = BYTE_W_DEFAULT,
    localparam int CNT_W = $clog2(ACC_W + 1)
) (
    input  logic [ACC_W-1:0]  src,
    input  logic [CNT_W-1:0]  eff_width,
    input  logic [BYTE_W-1:0] offset,
    input  logic              sign_fill,
    output logic [ACC_W-1:0]  res
);

    logic [ACC_W-1:0] shifted;
    logic             fill_bit;
    int               top_idx;

    always_comb begin
        shifted  = src >> offset;
        top_idx  = int'(eff_width) - 1;
        fill_bit = 1'b0;
        if (sign_fill && (eff_width != '0)) begin
            fill_bit = shifted[top_idx];
        end
        for (int i = 0; i < ACC_W; i++) begin
            res[i] = (i < int'(eff_width)) ? shifted[i] : fill_bit;
        end
    end

endmodule

// File: rtl/bfx_insert.sv
module bfx_insert
    import bfx_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEFAULT,
    parameter int BYTE_W = BYTE_W_DEFAULT,
    localparam int CNT_W = $clog2(ACC_W + 1)
) (
    input  logic [ACC_W-1:0]  src,
    input  logic [ACC_W-1:0]  dst,
    input  logic [CNT_W-1:0]  eff_width,
    input  logic [BYTE_W-1:0] offset,
    output logic [ACC_W-1:0]  res
);

    logic [ACC_W-1:0] low_mask;
    logic [ACC_W-1:0] field_mask;

    always_comb begin
        if (eff_width == '0) begin
            low_mask = '0;
        end else begin
            low_mask = {ACC_W{1'b1}} >> (ACC_W - int'(eff_width));
        end
        field_mask = low_mask << offset;
        res        = (dst & ~field_mask) | ((src << offset) & field_mask);
    end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfx_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEFAULT,
    parameter int BYTE_W = BYTE_W_DEFAULT,
    localparam int DESC_W = 2 * BYTE_W,
    localparam int CNT_W  = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              desc_imm,
    input  logic [DESC_W-1:0] desc,
    input  logic [ACC_W-1:0]  src_acc,
    input  logic [ACC_W-1:0]  dst_acc,
    output logic              busy,
    output logic [ACC_W-1:0]  result,
    output logic              res_valid
);

    typedef struct packed {
        bf_op_e            code;
        logic [DESC_W-1:0] field;
        logic [ACC_W-1:0]  src;
        logic [ACC_W-1:0]  dst;
    } bf_req_t;

    bf_req_t          in_req;
    bf_req_t          held_q;
    bf_req_t          work;
    logic             pend_q;
    logic             accept;
    logic             go_slow;

    logic [CNT_W-1:0]  eff_width;
    logic [BYTE_W-1:0] offset;
    logic [ACC_W-1:0]  ext_res;
    logic [ACC_W-1:0]  ins_res;
    logic [ACC_W-1:0]  next_res;

    always_comb begin
        in_req.code  = bf_op_e'(op);
        in_req.field = desc;
        in_req.src   = src_acc;
        in_req.dst   = dst_acc;
        accept       = start && !pend_q && op_accepted(in_req.code);
        go_slow      = op_needs_two(in_req.code, desc_imm);
        work         = pend_q ? held_q : in_req;
    end

    bfx_decode #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) decode_i (
        .desc      (work.field),
        .eff_width (eff_width),
        .offset    (offset)
    );

    bfx_extract #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) extract_i (
        .src       (work.src),
        .eff_width (eff_width),
        .offset    (offset),
        .sign_fill (work.code == OP_EXT_SIGNED),
        .res       (ext_res)
    );

    bfx_insert #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) insert_i (
        .src       (work.src),
        .dst       (work.dst),
        .eff_width (eff_width),
        .offset    (offset),
        .res       (ins_res)
    );

    assign next_res = (work.code == OP_INSERT) ? ins_res : ext_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            held_q    <= '0;
            result    <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (pend_q) begin
                result    <= next_res;
                res_valid <= 1'b1;
                pend_q    <= 1'b0;
            end else if (accept) begin
                if (go_slow) begin
                    held_q <= in_req;
                    pend_q <= 1'b1;
                end else begin
                    result    <= next_res;
                    res_valid <= 1'b1;
                end
            end
        end
    end

    assign busy = pend_q;

endmodule

// File: rtl/bfx_checker.sv
module bfx_checker #(
    parameter int ACC_W = 36
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [1:0]       op,
    input logic             desc_imm,
    input logic             busy,
    input logic [ACC_W-1:0] result,
    input logic             res_valid
);

    // R7: register-descriptor extract completes in one cycle
    a_r7_reg_extract_fast: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (op == 2'd0 || op == 2'd1) && !desc_imm) |=> (res_valid && !busy));

    // R8: slow operations go busy first
    a_r8_slow_enters_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (op == 2'd2 || (op != 2'd3 && desc_imm))) |=> (busy && !res_valid));

    // R8: busy cycle is followed by the result
    a_r8_busy_then_valid: assert property (@(posedge clk) disable iff (rst)
        busy |=> (res_valid && !busy));

    // R9: reserved code is ignored
    a_r9_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 2'd3) |=> (!res_valid && !busy));

    // R10: result holds between valid pulses
    a_r10_result_holds: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(result));

    // R10: valid only follows an accepted start or a busy cycle
    a_r10_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> ($past(start) || $past(busy)));

endmodule

bind bitfield_unit bfx_checker #(.ACC_W(ACC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .desc_imm  (desc_imm),
    .busy      (busy),
    .result    (result),
    .res_valid (res_valid)
);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;

    localparam int AW = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic          desc_imm = 1'b0;
    logic [15:0]   desc = '0;
    logic [AW-1:0] src_acc = '0;
    logic [AW-1:0] dst_acc = '0;
    logic          busy;
    logic [AW-1:0] result;
    logic          res_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bitfield_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op),
        .desc_imm  (desc_imm),
        .desc      (desc),
        .src_acc   (src_acc),
        .dst_acc   (dst_acc),
        .busy      (busy),
        .result    (result),
        .res_valid (res_valid)
    );

    // Reference model state
    logic          m_busy = 0;
    logic [1:0]    m_op = 0;
    logic [15:0]   m_desc = 0;
    logic [AW-1:0] m_src = 0;
    logic [AW-1:0] m_dst = 0;
    logic          e_valid = 0;
    logic          e_busy = 0;
    logic [AW-1:0] e_res = 0;
    string         e_tag = "R10";
    string         e_lat = "R10";

    // Bit-by-bit reference for R1..R6
    function automatic logic [AW-1:0] ref_calc(input logic [1:0] o, input logic [15:0] d,
                                               input logic [AW-1:0] s, input logic [AW-1:0] t);
        int w   = int'(d[15:8]);   // R1 width byte
        int off = int'(d[7:0]);    // R1 offset byte
        int top = -1;
        logic [AW-1:0] r;
        if (o == 2'd2) begin
            r = t;
            for (int j = 0; j < w; j++) if (off + j < AW) r[off+j] = s[j];
        end else begin
            r = '0;
            for (int j = 0; j < w; j++) if (off + j < AW) begin r[j] = s[off+j]; top = j; end
            if (o == 2'd0 && top >= 0)
                for (int k = top + 1; k < AW; k++) r[k] = r[top];
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic [15:0] d);
        int w   = int'(d[15:8]);
        int off = int'(d[7:0]);
        string base = (o == 2'd0) ? "R1 R2" : (o == 2'd1) ? "R1 R3" : "R1 R4";
        if (w == 0) return {base, " R5"};
        if (off + w > AW) return {base, " R6"};
        return base;
    endfunction

    task automatic check1(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs predicted for now, drive, predict next
    task automatic cyc(input logic s, input logic [1:0] o, input logic im,
                       input logic [15:0] d, input logic [AW-1:0] a, input logic [AW-1:0] b);
        logic nv;
        logic nb;
        @(negedge clk);
        check1({e_lat, " valid"}, AW'(res_valid), AW'(e_valid));
        check1({e_lat, " busy"}, AW'(busy), AW'(e_busy));
        if (e_valid) check1(e_tag, result, e_res);
        else         check1("R10 hold", result, e_res);
        start = s; op = o; desc_imm = im; desc = d; src_acc = a; dst_acc = b;
        nv = 0; nb = 0;
        if (m_busy) begin
            nv = 1; e_res = ref_calc(m_op, m_desc, m_src, m_dst);
            e_tag = tag_of(m_op, m_desc); e_lat = "R8";
        end else if (s && o != 2'd3) begin
            if (o == 2'd2 || im) begin
                nb = 1; m_op = o; m_desc = d; m_src = a; m_dst = b; e_lat = "R8";
            end else begin
                nv = 1; e_res = ref_calc(o, d, a, b); e_tag = tag_of(o, d); e_lat = "R7";
            end
        end else begin
            e_lat = (s || m_busy) ? "R9" : "R10";
        end
        m_busy = nb; e_valid = nv; e_busy = nb;
    endtask

    initial begin
        logic [63:0] r1;
        logic [63:0] r2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check1("R10 reset result", result, '0);
        check1("R10 reset valid", AW'(res_valid), '0);
        check1("R10 reset busy", AW'(busy), '0);
        // R2 R3 fast: field 0xA5 at offset 4, width 8
        cyc(1, 2'd0, 0, 16'h0804, 36'h0_0000_0A50, 36'h5_5555_5555);
        cyc(1, 2'd1, 0, 16'h0804, 36'h0_0000_0A50, 36'h5_5555_5555);
        cyc(1, 2'd0, 0, 16'h0804, 36'h0_0000_0750, '0);
        // R8 immediate extract, then start during busy (R9)
        cyc(1, 2'd0, 1, 16'h0C10, 36'h8_00F0_0000, '0);
        cyc(1, 2'd1, 0, 16'h0400, 36'hF_FFFF_FFFF, '0);
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        // R4 insert
        cyc(1, 2'd2, 0, 16'h0808, 36'h0_0000_00AB, 36'hF_FFFF_FFFF);
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        cyc(1, 2'd2, 1, 16'h1004, 36'h1_2345_BEEF, '0);
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        // R5 zero width
        cyc(1, 2'd0, 0, 16'h0003, 36'hF_FFFF_FFFF, '0);
        cyc(1, 2'd2, 0, 16'h0003, 36'hF_FFFF_FFFF, 36'h1_2345_6789);
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        // R6 clipping: top bits, offset beyond width, huge width
        cyc(1, 2'd0, 0, 16'h0C1E, 36'h8_4000_0000, '0);
        cyc(1, 2'd1, 0, 16'hFF20, 36'hA_0000_0000, '0);
        cyc(1, 2'd0, 0, 16'h0828, 36'hF_FFFF_FFFF, '0);
        cyc(1, 2'd2, 0, 16'hFF1C, 36'h0_0000_00FF, 36'h0);
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        cyc(1, 2'd2, 0, 16'h0830, 36'hF_FFFF_FFFF, 36'h0_1234_5678);
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        cyc(1, 2'd0, 0, 16'h2400, 36'h8_0000_0001, '0);
        // R9 reserved code
        cyc(1, 2'd3, 0, 16'h0804, 36'hF_FFFF_FFFF, '0);
        cyc(1, 2'd3, 1, 16'h0804, 36'hF_FFFF_FFFF, '0);
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            r1 = {$urandom, $urandom};
            r2 = {$urandom, $urandom};
            cyc(($urandom % 4) != 0, 2'($urandom % 4), 1'($urandom % 2),
                ($urandom % 8 == 0) ? 16'($urandom) : {8'($urandom % 40), 8'($urandom % 40)},
                r1[AW-1:0], r2[AW-1:0]);
        end
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        cyc(0, 2'd0, 0, 16'h0, '0, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule